// File: doc/BRIEF.md
# ATA PIO Cycle Timing Sequencer

This block runs one ATA-style register or PIO data cycle at a time on behalf of a host. The host presents a request with a direction, a 5-bit target selector and a 16-bit write word. The block then produces the device-side bus cycle. It holds the address and chip selects steady for a setup interval and pulses the read or write strobe for a programmed width. It then keeps the address steady through a recovery interval before it reports completion. Every phase length is a clock-cycle count taken from configuration inputs.

The device ready line can stretch the strobe beyond its programmed width. A timeout count bounds this stretch. When the bound is exceeded, the cycle is abandoned and an error is reported with the completion pulse. Read data is captured from the bus at the trailing edge of the read strobe. The data bus is presented as separate output, output-enable and input vectors, for connection to a pad ring.

Top module: `ata_pio_seq`

## Requirements
- R1: After reset, busy, done and err are low, both strobes are high, dev_cs_n is 2'b11 and dd_oe is low.
- R2: A request is accepted on a rising edge where req_valid is high and busy is low. A request presented while busy is high has no effect on the cycle in progress and starts no later cycle. busy is low in the cycle where done is high, so a request held high is accepted on that same edge.
- R3: After acceptance, dev_addr and dev_cs_n are driven for exactly cfg_setup cycles with both strobes high, and then the strobe falls.
- R4: With iordy high, the strobe (dior_n for reads, diow_n for writes) stays low for exactly cfg_pulse cycles.
- R5: After the strobe rises, dev_addr and dev_cs_n stay valid for a recovery interval. For reads it lasts cfg_recov cycles. For writes it lasts the larger of cfg_recov and cfg_hold. done then pulses high for one cycle.
- R6: dd_oe is high only on write cycles. It is high from the first strobe cycle through cfg_hold cycles after the strobe rises, and dd_out carries the request's write word while it is high.
- R7: On a read, rdata takes the value dd_in had in the last cycle of the strobe and is valid when done is high.
- R8: If iordy is low when the programmed width ends, the strobe stays low until the cycle after iordy is seen high. The strobe length is then max(cfg_pulse, cycles until iordy rises).
- R9: If the strobe has already been extended by cfg_tmo cycles and iordy is still low, the strobe rises and the cycle ends with no recovery. done and err pulse high together, and rdata is not updated.
- R10: A programmed count of zero in any timing field is treated as one cycle.
- R11: While busy, dev_addr equals req_sel[2:0]. dev_cs_n[0] is low when req_sel[3] is set, and dev_cs_n[1] is low when req_sel[4] is set. When idle, dev_addr is 0 and dev_cs_n is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_sel | input | 5 | [2:0] address, [3] chip select 0, [4] chip select 1 |
| req_wdata | input | 16 | Write word |
| cfg_setup | input | CNT_W | Address-to-strobe setup count |
| cfg_pulse | input | CNT_W | Strobe width count |
| cfg_recov | input | CNT_W | Recovery count after strobe |
| cfg_hold | input | CNT_W | Write data hold count after strobe |
| cfg_tmo | input | TMO_W | Maximum ready-wait extension |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Ready timeout, pulses with done |
| rdata | output | 16 | Captured read word |
| dev_addr | output | 3 | Device address lines |
| dev_cs_n | output | 2 | Device chip selects, active low |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| dd_out | output | 16 | Data bus output value |
| dd_oe | output | 1 | Data bus output enable |
| dd_in | input | 16 | Data bus input value |
| iordy | input | 1 | Device ready |

## Verification
The completion of one cycle and the acceptance of the next fall on the same clock edge. busy drops in the done cycle, so a request held high starts a new cycle at once. The bench provokes this by keeping req_valid asserted through a full cycle. It judges the result by seeing busy low while done is high and busy high one cycle later. The address is also checked again, with no gap cycle expected. The ready timeout is examined at its exact boundary, where the strobe is extended by cfg_tmo cycles with iordy rising in the last one, and one cycle past it.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

    localparam int CNT_W  = 4;
    localparam int TMO_W  = 8;
    localparam int DATA_W = 16;
    localparam int SEL_W  = 5;
    localparam int ADR_W  = 3;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [TMO_W-1:0]  tmo_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [SEL_W-1:0]  sel_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_RECOV
    } pio_phase_e;

    typedef struct packed {
        cnt_t setup;
        cnt_t pulse;
        cnt_t recov;
        cnt_t hold;
        tmo_t tmo;
    } pio_timing_t;

    function automatic cnt_t floor_one_cnt(input cnt_t v);
        return (v == '0) ? cnt_t'(1) : v;
    endfunction

    function automatic tmo_t floor_one_tmo(input tmo_t v);
        return (v == '0) ? tmo_t'(1) : v;
    endfunction

endpackage

// File: rtl/pio_seq_fsm.sv
module pio_seq_fsm
    import ata_pio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        start_write,
    input  logic        iordy,
    input  pio_timing_t tcfg,
    output pio_phase_e  phase,
    output cnt_t        cnt,
    output logic        txn_write,
    output logic        capture,
    output logic        done,
    output logic        err
);

    cnt_t setup_e, pulse_e, recov_e, hold_e, recov_len;
    tmo_t tmo_e, wait_cnt;
    logic width_met, abort;

    always_comb begin
        setup_e   = floor_one_cnt(tcfg.setup);
        pulse_e   = floor_one_cnt(tcfg.pulse);
        recov_e   = floor_one_cnt(tcfg.recov);
        hold_e    = floor_one_cnt(tcfg.hold);
        tmo_e     = floor_one_tmo(tcfg.tmo);
        recov_len = (txn_write && hold_e > recov_e) ? hold_e : recov_e;
        width_met = (phase == PH_STROBE) && (cnt >= pulse_e);
        capture   = width_met && iordy;
        abort     = width_met && !iordy && (wait_cnt == tmo_e);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= cnt_t'(1);
            wait_cnt  <= '0;
            txn_write <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase     <= PH_SETUP;
                        cnt       <= cnt_t'(1);
                        wait_cnt  <= '0;
                        txn_write <= start_write;
                    end
                end
                PH_SETUP: begin
                    if (cnt >= setup_e) begin
                        phase <= PH_STROBE;
                        cnt   <= cnt_t'(1);
                    end else begin
                        cnt <= cnt + cnt_t'(1);
                    end
                end
                PH_STROBE: begin
                    if (!width_met) begin
                        cnt <= cnt + cnt_t'(1);
                    end else if (iordy) begin
                        phase <= PH_RECOV;
                        cnt   <= cnt_t'(1);
                    end else if (abort) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                        err   <= 1'b1;
                    end else begin
                        wait_cnt <= wait_cnt + tmo_t'(1);
                    end
                end
                default: begin
                    if (cnt >= recov_len) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt + cnt_t'(1);
                    end
                end
            endcase
        end
    end

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        err |-> done); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5
    AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STROBE && $past(phase) != PH_STROBE) |-> $past(phase) == PH_SETUP); // R3
    AST_PULSE_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RECOV && $past(phase) == PH_STROBE) |-> $past(cnt) >= $past(pulse_e)); // R4

endmodule

// File: rtl/pio_bus_drv.sv
module pio_bus_drv
    import ata_pio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  sel_t                 req_sel,
    input  word_t                req_wdata,
    input  pio_phase_e           phase,
    input  cnt_t                 cnt,
    input  cnt_t                 hold_cfg,
    input  logic                 txn_write,
    input  logic                 capture,
    input  word_t                dd_in,
    output logic [ADR_W-1:0]     dev_addr,
    output logic [1:0]           dev_cs_n,
    output logic                 dior_n,
    output logic                 diow_n,
    output word_t                dd_out,
    output logic                 dd_oe,
    output word_t                rdata
);

    sel_t  sel_q;
    word_t wdata_q;
    cnt_t  hold_e;
    logic  active, strobing;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            if (start) begin
                sel_q   <= req_sel;
                wdata_q <= req_wdata;
            end
            if (capture && !txn_write) begin
                rdata <= dd_in;
            end
        end
    end

    always_comb begin
        hold_e   = floor_one_cnt(hold_cfg);
        active   = (phase != PH_IDLE);
        strobing = (phase == PH_STROBE);
        dev_addr = active ? sel_q[ADR_W-1:0] : '0;
        dev_cs_n = active ? ~sel_q[ADR_W+1:ADR_W] : 2'b11;
        dior_n   = !(strobing && !txn_write);
        diow_n   = !(strobing && txn_write);
        dd_oe    = txn_write && (strobing || (phase == PH_RECOV && cnt <= hold_e));
        dd_out   = dd_oe ? wdata_q : '0;
    end

    AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
        dd_oe |-> (txn_write && active)); // R6
    AST_NO_OE_ON_READ_STROBE: assert property (@(posedge clk) disable iff (rst)
        !dior_n |-> !dd_oe); // R6
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |-> ($stable(dev_addr) && $stable(dev_cs_n))); // R11

endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
    import ata_pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_pulse,
    input  logic [CNT_W-1:0]  cfg_recov,
    input  logic [CNT_W-1:0]  cfg_hold,
    input  logic [TMO_W-1:0]  cfg_tmo,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic [ADR_W-1:0]  dev_addr,
    output logic [1:0]        dev_cs_n,
    output logic              dior_n,
    output logic              diow_n,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe,
    input  logic [DATA_W-1:0] dd_in,
    input  logic              iordy
);

    pio_timing_t tcfg;
    pio_phase_e  phase;
    cnt_t        cnt;
    logic        txn_write, capture, start;

    assign tcfg  = '{setup: cfg_setup, pulse: cfg_pulse, recov: cfg_recov,
                     hold: cfg_hold, tmo: cfg_tmo};
    assign busy  = (phase != PH_IDLE);
    assign start = req_valid && !busy;

    pio_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_write (req_write),
        .iordy       (iordy),
        .tcfg        (tcfg),
        .phase       (phase),
        .cnt         (cnt),
        .txn_write   (txn_write),
        .capture     (capture),
        .done        (done),
        .err         (err)
    );

    pio_bus_drv u_bus (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req_sel   (req_sel),
        .req_wdata (req_wdata),
        .phase     (phase),
        .cnt       (cnt),
        .hold_cfg  (cfg_hold),
        .txn_write (txn_write),
        .capture   (capture),
        .dd_in     (dd_in),
        .dev_addr  (dev_addr),
        .dev_cs_n  (dev_cs_n),
        .dior_n    (dior_n),
        .diow_n    (diow_n),
        .dd_out    (dd_out),
        .dd_oe     (dd_oe),
        .rdata     (rdata)
    );

    AST_DONE_MEANS_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R2

endmodule

// File: tb/tb_ata_pio_seq.sv
`timescale 1ns/1ps
module tb_ata_pio_seq;

    typedef struct packed {
        logic        wr;
        logic [4:0]  sel;
        logic [3:0]  t1;
        logic [3:0]  t2;
        logic [3:0]  teoc;
        logic [3:0]  t4;
        logic [7:0]  rdy_at;
        logic [7:0]  tmo;
        logic [15:0] wdata;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 5'b01011, 4'd3, 4'd4, 4'd2, 4'd1, 8'd0,  8'd10, 16'hA5C3},
        '{1'b0, 5'b10111, 4'd2, 4'd5, 4'd3, 4'd2, 8'd0,  8'd10, 16'h0000},
        '{1'b1, 5'b01000, 4'd1, 4'd2, 4'd2, 4'd5, 8'd0,  8'd10, 16'h5A3C},
        '{1'b1, 5'b10101, 4'd0, 4'd0, 4'd0, 4'd0, 8'd0,  8'd10, 16'h1234},
        '{1'b0, 5'b01110, 4'd2, 4'd3, 4'd2, 4'd1, 8'd7,  8'd10, 16'h0000},
        '{1'b0, 5'b11001, 4'd1, 4'd2, 4'd2, 4'd1, 8'd20, 8'd4,  16'h0000},
        '{1'b1, 5'b10010, 4'd2, 4'd2, 4'd1, 4'd3, 8'd5,  8'd3,  16'hBEEF},
        '{1'b0, 5'b01101, 4'd1, 4'd1, 4'd1, 4'd1, 8'd3,  8'd0,  16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [4:0]  req_sel = '0;
    logic [15:0] req_wdata = '0;
    logic [3:0]  cfg_setup = 4'd1, cfg_pulse = 4'd1, cfg_recov = 4'd1, cfg_hold = 4'd1;
    logic [7:0]  cfg_tmo = 8'd1;
    logic        busy, done, err, dior_n, diow_n, dd_oe;
    logic [15:0] rdata, dd_out;
    logic [15:0] dd_in = '0;
    logic [2:0]  dev_addr;
    logic [1:0]  dev_cs_n;
    logic        iordy = 1'b1;

    int nchecks = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    ata_pio_seq dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_sel(req_sel), .req_wdata(req_wdata), .cfg_setup(cfg_setup),
        .cfg_pulse(cfg_pulse), .cfg_recov(cfg_recov), .cfg_hold(cfg_hold),
        .cfg_tmo(cfg_tmo), .busy(busy), .done(done), .err(err), .rdata(rdata),
        .dev_addr(dev_addr), .dev_cs_n(dev_cs_n), .dior_n(dior_n), .diow_n(diow_n),
        .dd_out(dd_out), .dd_oe(dd_oe), .dd_in(dd_in), .iordy(iordy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int one_min(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Runs one transfer from vector v. poke: present a stray request mid-cycle.
    // hold: keep req_valid high so the next request is taken on the done edge.
    task automatic run_xfer(input vec_t v, input bit poke, input bit hold);
        int e_setup, e_pulse, e_recov, e_hold, e_tmo, e_strobe, exp_rcv, exp_oe;
        int n_setup, n_strobe, n_recov, n_oe;
        int bad_addr, bad_data, bad_dir;
        bit seen, got_done, got_err, timeout;
        logic [15:0] last_d;
        string t_set, t_str, t_rec;
        e_setup = one_min(int'(v.t1));
        e_pulse = one_min(int'(v.t2));
        e_recov = one_min(int'(v.teoc));
        e_hold  = one_min(int'(v.t4));
        e_tmo   = one_min(int'(v.tmo));
        timeout = int'(v.rdy_at) > e_pulse + e_tmo;
        e_strobe = timeout ? e_pulse + e_tmo
                 : ((int'(v.rdy_at) > e_pulse) ? int'(v.rdy_at) : e_pulse);
        exp_rcv = timeout ? 0 : ((v.wr && e_hold > e_recov) ? e_hold : e_recov);
        exp_oe  = (v.wr && !timeout) ? e_hold : 0;
        t_set = (v.t1 == 0) ? "R10" : "R3";
        t_str = (v.t2 == 0) ? "R10" : (timeout ? "R9" : ((int'(v.rdy_at) > e_pulse) ? "R8" : "R4"));
        t_rec = (v.teoc == 0) ? "R10" : "R5";

        @(negedge clk);
        cfg_setup = v.t1; cfg_pulse = v.t2; cfg_recov = v.teoc; cfg_hold = v.t4;
        cfg_tmo = v.tmo;
        req_write = v.wr; req_sel = v.sel; req_wdata = v.wdata; req_valid = 1'b1;
        iordy = (v.rdy_at == 0);
        @(negedge clk);
        if (!hold) req_valid = 1'b0;
        n_setup = 0; n_strobe = 0; n_recov = 0; n_oe = 0;
        bad_addr = 0; bad_data = 0; bad_dir = 0;
        seen = 0; got_done = 0; got_err = 0; last_d = '0;
        for (int i = 0; i < 400 && !got_done; i++) begin
            if (done) begin
                got_done = 1;
                got_err = err;
            end else begin
                if (!busy || dev_addr != v.sel[2:0] || dev_cs_n != ~v.sel[4:3]) bad_addr++;
                if (!dior_n || !diow_n) begin
                    seen = 1;
                    n_strobe++;
                    if (v.wr ? !dior_n : !diow_n) bad_dir++;
                    if (v.wr && (!dd_oe || dd_out != v.wdata)) bad_data++;
                    if (!v.wr && dd_oe) bad_data++;
                    iordy = (n_strobe >= int'(v.rdy_at));
                    last_d = 16'hD000 ^ 16'(n_strobe * 37 + i);
                    dd_in = last_d;
                end else if (!seen) begin
                    n_setup++;
                end else begin
                    n_recov++;
                    if (dd_oe) begin
                        n_oe++;
                        if (dd_out != v.wdata) bad_data++;
                    end
                end
                if (poke && i == 2) begin
                    req_valid = 1'b1; req_sel = ~v.sel; req_write = ~v.wr;
                end else if (poke && i == 3) begin
                    req_valid = 1'b0;
                end
            end
            if (!got_done) @(negedge clk);
        end
        iordy = 1'b1;
        chk(got_done, "R5", int'(got_done), 1);
        chk(got_done && !busy, "R2", int'(busy), 0);
        chk(n_setup == e_setup, t_set, n_setup, e_setup);
        chk(n_strobe == e_strobe, t_str, n_strobe, e_strobe);
        chk(n_recov == exp_rcv, t_rec, n_recov, exp_rcv);
        chk(bad_addr == 0, "R11", bad_addr, 0);
        chk(bad_dir == 0, "R4", bad_dir, 0);
        chk(bad_data == 0 && n_oe == exp_oe, "R6", n_oe, exp_oe);
        chk(got_err == timeout, "R9", int'(got_err), int'(timeout));
        if (!v.wr && !timeout) chk(rdata == last_d, "R7", int'(rdata), int'(last_d));
        if (poke) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(!busy, "R2", int'(busy), 0);
            end
        end
        if (hold) begin
            @(negedge clk);
            chk(busy, "R2", int'(busy), 1);
            chk(dev_addr == v.sel[2:0] && dev_cs_n == ~v.sel[4:3], "R11", int'(dev_addr), int'(v.sel[2:0]));
            req_valid = 1'b0;
            got_done = 0;
            for (int i = 0; i < 400 && !got_done; i++) begin
                @(negedge clk);
                if (done) got_done = 1;
            end
            chk(got_done, "R2", int'(got_done), 1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle state after reset
        chk(!busy && !done && !err, "R1", int'({busy, done, err}), 0);
        chk(dior_n && diow_n, "R1", int'({dior_n, diow_n}), 3);
        chk(dev_cs_n == 2'b11 && dev_addr == 3'd0, "R1", int'(dev_cs_n), 3);
        chk(!dd_oe, "R1", int'(dd_oe), 0);

        for (int n = 0; n < NVEC; n++) run_xfer(VECS[n], 1'b0, 1'b0);

        // R2: stray request while busy is ignored
        run_xfer(VECS[0], 1'b1, 1'b0);
        run_xfer(VECS[1], 1'b1, 1'b0);
        // R2: completion and next acceptance on the same edge
        run_xfer(VECS[2], 1'b0, 1'b1);
        run_xfer(VECS[4], 1'b0, 1'b1);

        // R1: reset in the middle of a strobe returns to idle
        @(negedge clk);
        cfg_setup = 4'd1; cfg_pulse = 4'd8; req_write = 1'b1; req_sel = 5'b11111;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy && diow_n && !dd_oe && dev_cs_n == 2'b11, "R1", int'(busy), 0);

        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

endmodule